// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable model of a single-clock synchronous static RAM with registered inputs, a four-beat burst address generator and a pipelined read path. Each word is split into byte lanes of nine bits. On every rising edge the block samples its three chip selects, two address strobes, the burst-advance control, the write controls, the address and the write data. From these it decodes one of four cycle types: begin-burst, continue-burst, suspend-burst or deselect.

The two strobes do not behave alike. The processor-side strobe (`strobe_p_n`) has priority and always starts a read, whatever the write controls show. The controller-side strobe (`strobe_c_n`) starts a read or a write, depending on the write controls. Once a burst is open, later cycles with both strobes high step to the next burst address or stay on the current one. Those cycles may write or read. Read data goes through an output register and is put on the bus only while the asynchronous output enable is low. A sleep input freezes the block and turns the bus driver off.

Top module: `sync_burst_sram`

## Requirements
- R1: A burst begins at a rising edge only when `sel1_n`=0, `sel2_n`=0 and `sel3`=1, and a strobe is low. That cycle uses `addr_i`, and burst beat 0 sits at that address.
- R2: A begin cycle from `strobe_p_n`=0 (with `sel1_n`=0) is always a read and writes nothing, even while write controls are active. A later cycle of the same burst writes if its write controls are active.
- R3: A begin cycle from `strobe_c_n`=0 while `strobe_p_n` is high (or ignored) writes `din_i` at `addr_i` if any lane write is active. Otherwise it is a read. A write cycle never drives the bus.
- R4: `strobe_c_n`=0 while not selected is a deselect. So is `strobe_p_n`=0 with `sel1_n`=0 but `sel2_n`/`sel3` not selecting. A deselect closes the burst and drives nothing. `strobe_p_n` is ignored while `sel1_n`=1.
- R5: With both strobes high and `advance_n`=0, the open burst moves one beat on. Its low two address bits are start XOR beat when `linear_i`=0 (interleaved order).
- R6: With `linear_i`=1, the low two address bits are (start + beat) mod 4. The upper address bits stay fixed.
- R7: With both strobes high and `advance_n`=1, the burst stays on its current address. That cycle reads, or writes if the write controls are active.
- R8: Lane k covers `din_i`/`dout_o` bits [9k+8:9k], k=0..3. `wr_all_n`=0 writes all lanes. Otherwise `lane_wr_en_n`=0 writes the lanes whose `lane_sel_n` bit is 0. With no lane selected the cycle is a read.
- R9: While `sleep_i`=1, every other synchronous input is ignored: no write, no change of burst position, and `dout_oe_o`=0.
- R10: `dout_oe_o` follows `out_en_n` without waiting for a clock. It is 1 only while `out_en_n`=0 and the registered cycle is a read.
- R11: Read data from a cycle registered at edge N appears on `dout_o` with `dout_oe_o`=1 after edge N+1.
- R12: After reset nothing is driven and no burst is open, so a continue cycle does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| sleep_i | input | 1 | Power-down: freeze and release the bus |
| sel1_n | input | 1 | Chip select, active low; also gates `strobe_p_n` |
| sel2_n | input | 1 | Chip select, active low |
| sel3 | input | 1 | Chip select, active high |
| strobe_p_n | input | 1 | Processor-side address strobe, read-only begin |
| strobe_c_n | input | 1 | Controller-side address strobe, read or write begin |
| advance_n | input | 1 | 0 steps the burst, 1 holds it |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| linear_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr_i | input | AW | Word address |
| din_i | input | DW | Write data |
| dout_o | output | DW | Registered read data |
| dout_oe_o | output | 1 | Bus drive enable for `dout_o` |

## Verification
The bench builds the block with DEPTH=16, so the address is four bits wide and every word can be written and read back by both strobes. At this size the bench also covers all sixteen lane-select masks and every burst start offset in both burst orders, including wrap-around past the fourth beat. Expected data comes from a reference array and burst counter kept in the bench. The bench also steps through sleep, deselect, suspend and output-enable sequences and checks the bus cycle by cycle.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    typedef enum logic [1:0] {
        OP_DESEL,
        OP_BEGIN,
        OP_STEP,
        OP_HOLD
    } op_e;

    // low two address bits of burst beat 'beat' starting from 'start'
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       linear);
        return linear ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_burst_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel1_n,
    input  logic             sel2_n,
    input  logic             sel3,
    input  logic             strobe_p_n,
    input  logic             strobe_c_n,
    input  logic             advance_n,
    input  logic             wr_all_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output op_e              op_o,
    output logic             is_write_o,
    output logic [LANES-1:0] lane_we_o
);

    logic             selected;
    logic [LANES-1:0] mask;

    always_comb begin
        selected = !sel1_n && !sel2_n && sel3;
        if (!wr_all_n)          mask = '1;
        else if (!lane_wr_en_n) mask = ~lane_sel_n;
        else                    mask = '0;

        if (!strobe_p_n && !sel1_n) begin
            op_o       = selected ? OP_BEGIN : OP_DESEL;
            is_write_o = 1'b0;
        end else if (!strobe_c_n) begin
            op_o       = selected ? OP_BEGIN : OP_DESEL;
            is_write_o = selected && (|mask);
        end else begin
            op_o       = advance_n ? OP_HOLD : OP_STEP;
            is_write_o = |mask;
        end
        lane_we_o = is_write_o ? mask : '0;
    end

endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
    import sram_burst_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [1:0]    beat_i,
    input  logic          linear_i,
    output logic [AW-1:0] addr_o
);

    assign addr_o = {base_i[AW-1:2], beat_low(base_i[1:0], beat_i, linear_i)};

endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [DW-1:0]    rdata_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we_i[g]) cells[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            if (rd_en_i) rd_q <= cells[raddr_i];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_burst_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             sel1_n,
    input  logic             sel2_n,
    input  logic             sel3,
    input  logic             strobe_p_n,
    input  logic             strobe_c_n,
    input  logic             advance_n,
    input  logic             wr_all_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             linear_i,
    input  logic             out_en_n,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    din_i,
    output logic [DW-1:0]    dout_o,
    output logic             dout_oe_o
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [1:0]    beat;
        logic          act;
        logic          rd;
        logic [AW-1:0] rd_addr;
        logic          vld;
    } ctrl_t;

    ctrl_t            c_d, c_q;
    op_e              op;
    logic             is_write;
    logic [LANES-1:0] lane_we;
    logic [LANES-1:0] wr_lanes;
    logic [1:0]       beat_sel;
    logic [AW-1:0]    burst_addr;
    logic [AW-1:0]    eff_addr;

    sram_cmd_decode #(.LANES(LANES)) dec_i (
        .sel1_n      (sel1_n),
        .sel2_n      (sel2_n),
        .sel3        (sel3),
        .strobe_p_n  (strobe_p_n),
        .strobe_c_n  (strobe_c_n),
        .advance_n   (advance_n),
        .wr_all_n    (wr_all_n),
        .lane_wr_en_n(lane_wr_en_n),
        .lane_sel_n  (lane_sel_n),
        .op_o        (op),
        .is_write_o  (is_write),
        .lane_we_o   (lane_we)
    );

    assign beat_sel = (op == OP_STEP) ? (c_q.beat + 2'd1) : c_q.beat;

    sram_burst_addr #(.AW(AW)) badr_i (
        .base_i  (c_q.base),
        .beat_i  (beat_sel),
        .linear_i(linear_i),
        .addr_o  (burst_addr)
    );

    always_comb begin
        c_d      = c_q;
        c_d.rd   = 1'b0;
        c_d.vld  = c_q.rd && !sleep_i;
        wr_lanes = '0;
        eff_addr = addr_i;
        if (!sleep_i) begin
            unique case (op)
                OP_BEGIN: begin
                    c_d.base = addr_i;
                    c_d.beat = 2'd0;
                    c_d.act  = 1'b1;
                    if (is_write) begin
                        wr_lanes = lane_we;
                    end else begin
                        c_d.rd      = 1'b1;
                        c_d.rd_addr = addr_i;
                    end
                end
                OP_DESEL: begin
                    c_d.act = 1'b0;
                end
                default: begin
                    if (c_q.act) begin
                        c_d.beat = beat_sel;
                        eff_addr = burst_addr;
                        if (is_write) begin
                            wr_lanes = lane_we;
                        end else begin
                            c_d.rd      = 1'b1;
                            c_d.rd_addr = burst_addr;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    sram_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) store_i (
        .clk    (clk),
        .we_i   (wr_lanes),
        .waddr_i(eff_addr),
        .wdata_i(din_i),
        .rd_en_i(c_q.rd && !sleep_i),
        .raddr_i(c_q.rd_addr),
        .rdata_o(dout_o)
    );

    assign dout_oe_o = c_q.vld && !out_en_n && !sleep_i;

endmodule

// File: rtl/sram_burst_checks.sv
module sram_burst_checks (
    input logic clk,
    input logic rst_n,
    input logic sleep_i,
    input logic sel1_n,
    input logic sel2_n,
    input logic sel3,
    input logic strobe_p_n,
    input logic strobe_c_n,
    input logic wr_all_n,
    input logic out_en_n,
    input logic dout_oe_o
);

    // R9: sleeping block never drives
    assert_sleep_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !dout_oe_o);

    // R10: output enable high keeps the bus released
    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dout_oe_o);

    // R4: controller strobe while unselected releases the bus one cycle on
    assert_desel_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !strobe_c_n && sel1_n) |=> ##1 !dout_oe_o);

    // R3: a global write begun by the controller strobe drives nothing
    assert_cwrite_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && strobe_p_n && !strobe_c_n && !sel1_n && !sel2_n && sel3 && !wr_all_n)
        |=> ##1 !dout_oe_o);

    // R2: processor strobe begin is a read even with write controls active
    assert_pread_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !strobe_p_n && !sel1_n && !sel2_n && sel3) ##1 !sleep_i
        |=> (sleep_i || out_en_n || dout_oe_o));

endmodule

bind sync_burst_sram sram_burst_checks chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep_i),
    .sel1_n    (sel1_n),
    .sel2_n    (sel2_n),
    .sel3      (sel3),
    .strobe_p_n(strobe_p_n),
    .strobe_c_n(strobe_c_n),
    .wr_all_n  (wr_all_n),
    .out_en_n  (out_en_n),
    .dout_oe_o (dout_oe_o)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;

    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int DW    = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep_i, sel1_n, sel2_n, sel3, strobe_p_n, strobe_c_n;
    logic          advance_n, wr_all_n, lane_wr_en_n, linear_i, out_en_n;
    logic [3:0]    lane_sel_n;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] din_i;
    logic [DW-1:0] dout_o;
    logic          dout_oe_o;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem_m [DEPTH];
    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;
    logic          m_act = 1'b0;
    logic          p_rd = 1'b0;
    logic [DW-1:0] p_data = '0;
    string         p_tag = "R12";

    always #2 clk = ~clk;

    sync_burst_sram #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .sel1_n(sel1_n),
        .sel2_n(sel2_n), .sel3(sel3), .strobe_p_n(strobe_p_n),
        .strobe_c_n(strobe_c_n), .advance_n(advance_n), .wr_all_n(wr_all_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .linear_i(linear_i), .out_en_n(out_en_n), .addr_i(addr_i),
        .din_i(din_i), .dout_o(dout_o), .dout_oe_o(dout_oe_o)
    );

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return (36'(a) << 22) ^ (36'(k) << 5) ^ 36'h5_3C96_A5F1 ^ (36'(a) * 36'd7919);
    endfunction

    function automatic logic [AW-1:0] m_addr(input logic [1:0] b);
        logic [1:0] lo;
        lo = linear_i ? (m_base[1:0] + b) : (m_base[1:0] ^ b);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic expect_oe(input string tag, input logic on, input logic [DW-1:0] data);
        checks++;
        if (on) begin
            if (dout_oe_o !== 1'b1 || dout_o !== data) begin
                errors++;
                $display("FAIL %s: oe=%b data=%h expected oe=1 data=%h", tag, dout_oe_o, dout_o, data);
            end
        end else if (dout_oe_o !== 1'b0) begin
            errors++;
            $display("FAIL %s: oe=%b expected oe=0", tag, dout_oe_o);
        end
    endtask

    task automatic defaults();
        sleep_i = 0; sel1_n = 0; sel2_n = 0; sel3 = 1;
        strobe_p_n = 1; strobe_c_n = 1; advance_n = 1;
        wr_all_n = 1; lane_wr_en_n = 1; lane_sel_n = 4'hF;
    endtask

    task automatic write_m(input logic [AW-1:0] a, input logic [3:0] lanes);
        for (int l = 0; l < 4; l++)
            if (lanes[l]) mem_m[a][l*9 +: 9] = din_i[l*9 +: 9];
    endtask

    // one clock: model the edge, then check the previous cycle's read
    task automatic tick(input string tag);
        logic          sel, wr, n_rd;
        logic [3:0]    lanes;
        logic [DW-1:0] n_data;
        logic [AW-1:0] ea;
        @(posedge clk);
        n_rd = 0; n_data = '0;
        if (!sleep_i) begin
            sel = !sel1_n && !sel2_n && sel3;
            lanes = !wr_all_n ? 4'hF : (!lane_wr_en_n ? ~lane_sel_n : 4'h0);
            wr = |lanes;
            if (!strobe_p_n && !sel1_n) begin
                if (sel) begin
                    m_base = addr_i; m_beat = 0; m_act = 1;
                    n_rd = 1; n_data = mem_m[addr_i];
                end else m_act = 0;
            end else if (!strobe_c_n) begin
                if (sel) begin
                    m_base = addr_i; m_beat = 0; m_act = 1;
                    if (wr) write_m(addr_i, lanes);
                    else begin n_rd = 1; n_data = mem_m[addr_i]; end
                end else m_act = 0;
            end else if (m_act) begin
                if (!advance_n) m_beat = m_beat + 2'd1;
                ea = m_addr(m_beat);
                if (wr) write_m(ea, lanes);
                else begin n_rd = 1; n_data = mem_m[ea]; end
            end
        end
        @(negedge clk);
        expect_oe(p_tag, p_rd && !sleep_i && !out_en_n, p_data);
        p_rd = n_rd; p_data = n_data; p_tag = tag;
    endtask

    task automatic begin_c(input string tag, input int a, input logic wr, input logic [DW-1:0] d);
        defaults(); strobe_c_n = 0; addr_i = AW'(a); wr_all_n = !wr; din_i = d; tick(tag);
    endtask

    task automatic begin_p(input string tag, input int a, input logic wr, input logic [DW-1:0] d);
        defaults(); strobe_p_n = 0; addr_i = AW'(a); wr_all_n = !wr; din_i = d; tick(tag);
    endtask

    task automatic burst(input string tag, input logic step, input logic wr, input logic [DW-1:0] d);
        defaults(); advance_n = !step; wr_all_n = !wr; din_i = d; addr_i = '0; tick(tag);
    endtask

    task automatic desel(input string tag);
        defaults(); sel1_n = 1; strobe_c_n = 0; tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        defaults(); linear_i = 0; out_en_n = 0; addr_i = '0; din_i = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        expect_oe("R12", 1'b0, '0);
        rst_n = 1;
        // R12: continue with no open burst does nothing
        burst("R12", 1'b1, 1'b0, '0);
        burst("R12", 1'b1, 1'b1, 36'h1);

        // R3 R8: global writes of every word through the controller strobe
        for (int a = 0; a < DEPTH; a++) begin_c("R3", a, 1'b1, pat(a, 0));
        // R1 R11: read every word back
        for (int a = 0; a < DEPTH; a++) begin_c("R1", a, 1'b0, '0);

        // R2: processor strobe with write active still reads old data
        begin_p("R2", 5, 1'b1, 36'hF_FFFF_FFFF);
        desel("R2");
        begin_c("R2", 5, 1'b0, '0);

        // R8: every lane mask on lane-enabled writes, then read back
        for (int m = 0; m < 16; m++) begin
            defaults(); strobe_c_n = 0; addr_i = AW'(m);
            lane_wr_en_n = 0; lane_sel_n = ~4'(m); din_i = ~pat(m, 1);
            tick("R8");
        end
        // R8: lane selects without lane enable are a read
        defaults(); strobe_c_n = 0; addr_i = 4'd6; lane_sel_n = 4'h0; din_i = '0; tick("R8");
        for (int a = 0; a < DEPTH; a++) begin_c("R8", a, 1'b0, '0);

        // R5 R6: every start offset in both orders, six beats to wrap
        for (int lin = 0; lin < 2; lin++) begin
            linear_i = lin[0];
            for (int s = 0; s < 4; s++) begin
                begin_c(lin ? "R6" : "R5", 8 + s, 1'b0, '0);
                for (int k = 0; k < 5; k++) burst(lin ? "R6" : "R5", 1'b1, 1'b0, '0);
            end
        end
        linear_i = 0;

        // R7 R2: suspend writes and reads on a processor-begun burst
        begin_p("R2", 2, 1'b0, '0);
        burst("R7", 1'b0, 1'b1, pat(2, 7));
        burst("R7", 1'b0, 1'b0, '0);
        burst("R7", 1'b0, 1'b0, '0);
        burst("R5", 1'b1, 1'b0, '0);
        burst("R5", 1'b1, 1'b1, pat(0, 7));
        begin_c("R7", 0, 1'b0, '0);

        // R4: deselect variants and processor strobe ignored when sel1_n high
        begin_c("R4", 4, 1'b0, '0);
        defaults(); strobe_p_n = 0; sel1_n = 1; tick("R4");
        defaults(); strobe_p_n = 0; sel3 = 0; addr_i = 4'd1; tick("R4");
        burst("R4", 1'b1, 1'b0, '0);
        begin_c("R4", 4, 1'b0, '0);
        defaults(); strobe_c_n = 0; sel2_n = 1; wr_all_n = 0; din_i = '0; addr_i = 4'd4; tick("R4");
        burst("R4", 1'b0, 1'b1, '0);
        begin_c("R4", 4, 1'b0, '0);

        // R9: writes and steps during sleep are ignored
        begin_c("R9", 3, 1'b0, '0);
        defaults(); sleep_i = 1; strobe_c_n = 0; wr_all_n = 0; addr_i = 4'd7; din_i = '0; tick("R9");
        defaults(); sleep_i = 1; advance_n = 0; tick("R9");
        burst("R9", 1'b1, 1'b0, '0);
        begin_c("R9", 7, 1'b0, '0);
        desel("R9");

        // R10: output enable acts without a clock edge
        out_en_n = 1;
        begin_c("R10", 9, 1'b0, '0);
        defaults(); sel1_n = 1; strobe_c_n = 0; tick("R10");
        out_en_n = 0; #1;
        expect_oe("R10", 1'b1, mem_m[9]);
        out_en_n = 1; #1;
        expect_oe("R10", 1'b0, '0);
        out_en_n = 0;
        desel("R11");
        desel("R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule